// File: doc/BRIEF.md
# E1 Line Transmit Source Selector

This block sits in one channel of a multi-channel E1 line interface and decides what reaches the channel's bipolar transmit rails. It can pass through the payload rails supplied by the framer. It can send an all-ones pattern, either because software forces it or, when automatic mode is enabled, because the receiver has lost the line. It can also send the channel's own received data back out, which is remote loopback. It also drives the enable for the output pad: the channel is tri-stated unless its own enable bit and the global output-enable pin are both high.

Software can choose the clock edges used at both ends. A control bit selects whether the incoming transmit rails are captured on the falling or the rising edge of the transmit clock. A second bit selects whether the outgoing receive rails change on the rising or the falling edge of the receive clock. The loss-of-signal flag comes from another clock domain and passes through a two-flop synchronizer before it affects source selection. Every source switch happens at a rising transmit-clock edge, so no partial pulse reaches the line. The all-ones pattern is sent as alternating marks: one mark on the positive rail, then one on the negative rail, and so on.

The loopback path re-times the receive outputs with the transmit clock. It assumes that the transmit clock is the recovered receive clock while loopback is active.

Top module: `e1_tx_source_sel`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `tx_oe`=0, `tx_pos`=0, `tx_neg`=0, `rx_pos`=0 and `rx_neg`=0.
- R2: One transmit-clock edge after it is sampled, `tx_oe` equals `cfg_drv_en` AND `oe_pin`. A low `oe_pin` forces `tx_oe` to 0 regardless of every other setting.
- R3: With no alternative source selected, `tx_pos`/`tx_neg` repeat the captured `tx_pos_in`/`tx_neg_in` bits.
- R4: The all-ones pattern puts exactly one mark on the rails in each bit period. The marks alternate rails on successive periods, and the first mark after a switch into all-ones is on `tx_pos`.
- R5: When `cfg_ones_auto`=1 and `rx_los`=1, all-ones starts on the third rising transmit edge after `rx_los` rises and stops on the third edge after it falls. With `rx_los`=0, `cfg_ones_auto` has no effect on the rails.
- R6: Sources are ranked loopback (`cfg_loop`), then forced all-ones (`cfg_ones_force`), then automatic all-ones, then payload.
- R7: With `cfg_loop`=1, `tx_pos`/`tx_neg` show the values of `rx_pos`/`rx_neg` sampled at the previous rising transmit edge.
- R8: With `cfg_tclk_inv`=0, payload is captured on the falling transmit edge and appears after the next rising edge. With `cfg_tclk_inv`=1, it is captured on a rising edge and appears one rising edge later.
- R9: With `cfg_rclk_inv`=0, `rx_pos`/`rx_neg` change at the rising receive edge. With `cfg_rclk_inv`=1, they change at the falling receive edge.
- R10: `tx_pos`, `tx_neg` and `tx_oe` change only at rising transmit edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit bit clock |
| rx_clk | input | 1 | Recovered receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loop | input | 1 | Remote loopback select |
| cfg_ones_force | input | 1 | Forced all-ones select |
| cfg_ones_auto | input | 1 | All-ones on loss of signal enable |
| cfg_drv_en | input | 1 | Channel driver enable |
| cfg_tclk_inv | input | 1 | Transmit capture edge: 0 falling, 1 rising |
| cfg_rclk_inv | input | 1 | Receive update edge: 0 rising, 1 falling |
| oe_pin | input | 1 | Global output enable, shared by all channels |
| rx_los | input | 1 | Receive loss of signal, asynchronous |
| tx_pos_in | input | 1 | Payload positive rail |
| tx_neg_in | input | 1 | Payload negative rail |
| rx_pos_in | input | 1 | Recovered positive rail |
| rx_neg_in | input | 1 | Recovered negative rail |
| tx_pos | output | 1 | Line positive rail |
| tx_neg | output | 1 | Line negative rail |
| tx_oe | output | 1 | Line driver enable (0 = tri-state) |
| rx_pos | output | 1 | Re-timed receive positive rail |
| rx_neg | output | 1 | Re-timed receive negative rail |

## Verification
The bench drives inputs 1.25 ns after a rising edge and samples at the same offset, so each result is read a fixed number of rising edges later. Control and enable changes are due one edge later. Payload is due one edge later with falling capture and two edges later with rising capture. Loopback data is due two edges after it enters `rx_pos_in`. A change on `rx_los` shows at the third edge. For the receive update edge, the bench also samples 3.75 ns after the edge, between the falling edge and the next rising edge. The table vectors are held for six cycles so every path has settled before they are checked. The directed tests count the edges exactly.

// File: rtl/e1_txsel_pkg.sv
`timescale 1ns/1ps
package e1_txsel_pkg;

    typedef enum logic [1:0] {
        SRC_PAYLOAD     = 2'd0,
        SRC_ONES_AUTO   = 2'd1,
        SRC_ONES_FORCED = 2'd2,
        SRC_LOOP        = 2'd3
    } tx_src_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rails_t;

    localparam int RAIL_W = $bits(rails_t);

    // Fixed ranking: loopback, forced ones, loss-triggered ones, payload.
    function automatic tx_src_e pick_source(input logic loop_en,
                                            input logic force_en,
                                            input logic auto_en,
                                            input logic los);
        if (loop_en)             return SRC_LOOP;
        else if (force_en)       return SRC_ONES_FORCED;
        else if (auto_en && los) return SRC_ONES_AUTO;
        else                     return SRC_PAYLOAD;
    endfunction

    function automatic logic is_ones(input tx_src_e s);
        return (s == SRC_ONES_AUTO) || (s == SRC_ONES_FORCED);
    endfunction

    // Phase 0 marks the positive rail, phase 1 the negative rail.
    function automatic rails_t ones_mark(input logic phase);
        rails_t r;
        r.pos = ~phase;
        r.neg = phase;
        return r;
    endfunction

endpackage

// File: rtl/e1_txsel_sync.sv
`timescale 1ns/1ps
module e1_txsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/e1_txsel_edgecap.sv
`timescale 1ns/1ps
module e1_txsel_edgecap #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_rise,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= d;
    end

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= d;
    end

    assign q = sel_rise ? rise_q : fall_q;
endmodule

// File: rtl/e1_tx_source_sel.sv
`timescale 1ns/1ps
module e1_tx_source_sel
    import e1_txsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic tx_clk,
    input  logic rx_clk,
    input  logic rst,
    input  logic cfg_loop,
    input  logic cfg_ones_force,
    input  logic cfg_ones_auto,
    input  logic cfg_drv_en,
    input  logic cfg_tclk_inv,
    input  logic cfg_rclk_inv,
    input  logic oe_pin,
    input  logic rx_los,
    input  logic tx_pos_in,
    input  logic tx_neg_in,
    input  logic rx_pos_in,
    input  logic rx_neg_in,
    output logic tx_pos,
    output logic tx_neg,
    output logic tx_oe,
    output logic rx_pos,
    output logic rx_neg
);
    logic              los_s;
    logic [RAIL_W-1:0] pay_cap;
    logic [RAIL_W-1:0] rx_cap;
    tx_src_e           src;
    rails_t            nxt;
    rails_t            line_q;
    logic              phase_q;
    logic              oe_q;

    e1_txsel_sync #(.STAGES(SYNC_STAGES)) u_los_sync (
        .clk (tx_clk),
        .rst (rst),
        .d   (rx_los),
        .q   (los_s)
    );

    // Transmit capture: rising edge only when the invert bit is set.
    e1_txsel_edgecap #(.W(RAIL_W)) u_tx_cap (
        .clk      (tx_clk),
        .rst      (rst),
        .sel_rise (cfg_tclk_inv),
        .d        ({tx_pos_in, tx_neg_in}),
        .q        (pay_cap)
    );

    // Receive update: rising edge unless the invert bit is set.
    e1_txsel_edgecap #(.W(RAIL_W)) u_rx_cap (
        .clk      (rx_clk),
        .rst      (rst),
        .sel_rise (~cfg_rclk_inv),
        .d        ({rx_pos_in, rx_neg_in}),
        .q        (rx_cap)
    );

    assign rx_pos = rx_cap[1];
    assign rx_neg = rx_cap[0];

    always_comb begin
        src = pick_source(cfg_loop, cfg_ones_force, cfg_ones_auto, los_s);
        unique case (src)
            SRC_LOOP:        nxt = rails_t'({rx_pos, rx_neg});
            SRC_ONES_FORCED,
            SRC_ONES_AUTO:   nxt = ones_mark(phase_q);
            default:         nxt = rails_t'(pay_cap);
        endcase
    end

    // Single register stage at the bit boundary for rails and enable.
    always_ff @(posedge tx_clk) begin
        if (rst) begin
            line_q  <= '0;
            phase_q <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            line_q  <= nxt;
            phase_q <= is_ones(src) ? ~phase_q : 1'b0;
            oe_q    <= cfg_drv_en & oe_pin;
        end
    end

    assign tx_pos = line_q.pos;
    assign tx_neg = line_q.neg;
    assign tx_oe  = oe_q;
endmodule

// File: rtl/e1_tx_source_sel_chk.sv
`timescale 1ns/1ps
module e1_tx_source_sel_chk (
    input logic tx_clk,
    input logic rst,
    input logic cfg_loop,
    input logic cfg_ones_force,
    input logic cfg_drv_en,
    input logic oe_pin,
    input logic tx_pos,
    input logic tx_neg,
    input logic tx_oe,
    input logic rx_pos,
    input logic rx_neg
);
    logic forced_q;

    always_ff @(posedge tx_clk) begin
        if (rst) forced_q <= 1'b0;
        else     forced_q <= cfg_ones_force && !cfg_loop;
    end

    assert_reset_quiet_R1: assert property (@(posedge tx_clk)
        rst |=> (!tx_oe && !tx_pos && !tx_neg));

    assert_oe_gate_R2: assert property (@(posedge tx_clk) disable iff (rst)
        (!oe_pin || !cfg_drv_en) |=> !tx_oe);

    assert_single_mark_R4: assert property (@(posedge tx_clk) disable iff (rst)
        (cfg_ones_force && !cfg_loop) |=> (tx_pos != tx_neg));

    assert_mark_alternates_R4: assert property (@(posedge tx_clk) disable iff (rst)
        (cfg_ones_force && !cfg_loop && forced_q)
            |=> (tx_pos == $past(tx_neg) && tx_neg == $past(tx_pos)));

    // Holds when the transmit clock is the recovered clock during loopback.
    assert_loop_wins_R7: assert property (@(posedge tx_clk) disable iff (rst)
        cfg_loop |=> (tx_pos == $past(rx_pos) && tx_neg == $past(rx_neg)));
endmodule

bind e1_tx_source_sel e1_tx_source_sel_chk u_chk (
    .tx_clk         (tx_clk),
    .rst            (rst),
    .cfg_loop       (cfg_loop),
    .cfg_ones_force (cfg_ones_force),
    .cfg_drv_en     (cfg_drv_en),
    .oe_pin         (oe_pin),
    .tx_pos         (tx_pos),
    .tx_neg         (tx_neg),
    .tx_oe          (tx_oe),
    .rx_pos         (rx_pos),
    .rx_neg         (rx_neg)
);

// File: tb/tb_e1_tx_source_sel.sv
`timescale 1ns/1ps
module tb_e1_tx_source_sel;
    logic clk = 1'b0;
    logic rst;
    logic cfg_loop, cfg_ones_force, cfg_ones_auto, cfg_drv_en;
    logic cfg_tclk_inv, cfg_rclk_inv, oe_pin, rx_los;
    logic tx_pos_in, tx_neg_in, rx_pos_in, rx_neg_in;
    logic tx_pos, tx_neg, tx_oe, rx_pos, rx_neg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    e1_tx_source_sel dut (
        .tx_clk(clk), .rx_clk(clk), .rst(rst),
        .cfg_loop(cfg_loop), .cfg_ones_force(cfg_ones_force),
        .cfg_ones_auto(cfg_ones_auto), .cfg_drv_en(cfg_drv_en),
        .cfg_tclk_inv(cfg_tclk_inv), .cfg_rclk_inv(cfg_rclk_inv),
        .oe_pin(oe_pin), .rx_los(rx_los),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
        .rx_pos_in(rx_pos_in), .rx_neg_in(rx_neg_in),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_oe(tx_oe),
        .rx_pos(rx_pos), .rx_neg(rx_neg)
    );

    // Vector bits: loop force auto los p n rp rn kind[1:0]
    // kind 0 = payload, 1 = all-ones, 2 = loopback
    localparam logic [9:0] VEC [0:7] = '{
        10'b0000_10_01_00,
        10'b0010_01_10_00,
        10'b0011_11_01_01,
        10'b0100_10_11_01,
        10'b1100_01_10_10,
        10'b1011_10_01_10,
        10'b0111_00_10_01,
        10'b0001_11_01_00
    };

    task automatic tick;
        @(posedge clk);
        #1.25;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] s0;
        rst = 1'b1;
        cfg_loop = 0; cfg_ones_force = 0; cfg_ones_auto = 0;
        cfg_drv_en = 1; cfg_tclk_inv = 0; cfg_rclk_inv = 0;
        oe_pin = 1; rx_los = 0;
        tx_pos_in = 1; tx_neg_in = 1; rx_pos_in = 1; rx_neg_in = 1;
        #1.25;
        repeat (3) tick;
        // R1: reset dominates enables and live data
        chk("R1", "tx_oe", {1'b0, tx_oe}, 2'b00);
        chk("R1", "tx rails", {tx_pos, tx_neg}, 2'b00);
        chk("R1", "rx rails", {rx_pos, rx_neg}, 2'b00);
        tx_pos_in = 0; tx_neg_in = 0; rx_pos_in = 0; rx_neg_in = 0;
        rst = 1'b0;
        tick;
        chk("R2", "oe both high", {1'b0, tx_oe}, 2'b01);
        oe_pin = 0; tick;
        chk("R2", "oe pin low", {1'b0, tx_oe}, 2'b00);
        oe_pin = 1; cfg_drv_en = 0; tick;
        chk("R2", "drv bit low", {1'b0, tx_oe}, 2'b00);
        cfg_drv_en = 1; tick;
        chk("R2", "re-enabled", {1'b0, tx_oe}, 2'b01);

        // Table walk: R3 payload, R4 ones, R5 auto gating, R6 priority
        for (int i = 0; i < 8; i++) begin
            logic [9:0] v;
            string rq;
            v = VEC[i];
            cfg_loop = v[9]; cfg_ones_force = v[8]; cfg_ones_auto = v[7];
            rx_los = v[6]; tx_pos_in = v[5]; tx_neg_in = v[4];
            rx_pos_in = v[3]; rx_neg_in = v[2];
            rq = (i >= 4 && i <= 6) ? "R6" : (i == 3) ? "R4" :
                 (i == 1 || i == 2) ? "R5" : "R3";
            repeat (6) tick;
            case (v[1:0])
                2'd0: chk(rq, "payload", {tx_pos, tx_neg}, v[5:4]);
                2'd2: chk(rq, "loopback", {tx_pos, tx_neg}, v[3:2]);
                default: begin
                    s0 = {tx_pos, tx_neg};
                    chk(rq, "one mark", {1'b0, s0[1] ^ s0[0]}, 2'b01);
                    tick;
                    chk(rq, "mark flips", {tx_pos, tx_neg}, {s0[0], s0[1]});
                end
            endcase
        end
        cfg_loop = 0; cfg_ones_force = 0; cfg_ones_auto = 0; rx_los = 0;
        tx_pos_in = 0; tx_neg_in = 0; rx_pos_in = 0; rx_neg_in = 0;
        repeat (4) tick;

        // R8: capture edge
        tx_pos_in = 1; tick;
        chk("R8", "falling capture", {tx_pos, tx_neg}, 2'b10);
        tx_pos_in = 0; tick;
        chk("R8", "falling clear", {tx_pos, tx_neg}, 2'b00);
        cfg_tclk_inv = 1; tick;
        tx_neg_in = 1; tick;
        chk("R8", "rising not yet", {tx_pos, tx_neg}, 2'b00);
        tx_neg_in = 0; tick;
        chk("R8", "rising capture", {tx_pos, tx_neg}, 2'b01);
        tick;
        chk("R8", "rising clear", {tx_pos, tx_neg}, 2'b00);
        cfg_tclk_inv = 0; tick;

        // R9: receive update edge
        rx_pos_in = 1; #2.5;
        chk("R9", "rising mode mid", {rx_pos, rx_neg}, 2'b00);
        #2.5;
        chk("R9", "rising mode edge", {rx_pos, rx_neg}, 2'b10);
        rx_pos_in = 0; cfg_rclk_inv = 1; tick;
        rx_neg_in = 1; #2.5;
        chk("R9", "falling mode mid", {rx_pos, rx_neg}, 2'b01);
        #2.5;
        rx_neg_in = 0; cfg_rclk_inv = 0; repeat (2) tick;

        // R5 timing and R4 start phase, R10 mid-period stability
        cfg_ones_auto = 1; rx_los = 1;
        tick; chk("R5", "edge1 payload", {tx_pos, tx_neg}, 2'b00);
        tick; chk("R5", "edge2 payload", {tx_pos, tx_neg}, 2'b00);
        tick; chk("R4", "first mark pos", {tx_pos, tx_neg}, 2'b10);
        tick; chk("R4", "second mark neg", {tx_pos, tx_neg}, 2'b01);
        #2.5; chk("R10", "stable mid period", {tx_pos, tx_neg}, 2'b01);
        #2.5; chk("R10", "next period", {tx_pos, tx_neg}, 2'b10);
        rx_los = 0;
        tick; chk("R5", "release edge1", {tx_pos, tx_neg}, 2'b01);
        tick; chk("R5", "release edge2", {tx_pos, tx_neg}, 2'b10);
        tick; chk("R5", "release edge3", {tx_pos, tx_neg}, 2'b00);
        cfg_ones_auto = 0;

        // R7 loopback latency
        cfg_loop = 1; rx_pos_in = 1;
        tick; chk("R7", "loop edge1", {tx_pos, tx_neg}, 2'b00);
        tick; chk("R7", "loop edge2", {tx_pos, tx_neg}, 2'b10);
        cfg_loop = 0; rx_pos_in = 0;
        tick;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule